// File: doc/BRIEF.md
# CPU Address Window Decoder with PCI Memory Override

This block looks at a 32-bit CPU address and names the PCI memory window it targets. There are two windows, Mem0 and Mem1. Each is set by an 11-bit low decode register whose bits stand for CPU address bits 31:21. In the default mode each window spans 256 MB. A window matches when address bits 31:28 equal bits 10:7 of its register.

A 2-bit override field can widen Mem0. With the override on, Mem0 is chosen by comparing only one or two of the top address bits against the top bits of the Mem0 register. That gives a 2 GB or a 1 GB window. When the override compare fails, Mem0 does not match, and the address is still decoded against Mem1 as usual. The decision is purely combinational. The configuration values come straight from register outputs elsewhere in the chip. The result is a one-hot choice among Mem0, Mem1 and no target.

Top module: `pci_win_decode`

## Requirements
- R1: With the override off, `hit_mem0` is 1 when `cpu_addr[31:28]` equals `mem0_base[10:7]`.
- R2: With the override off, `hit_mem1` is 1 when `cpu_addr[31:28]` equals `mem1_base[10:7]` and Mem0 does not match.
- R3: When Mem0 and Mem1 both match, only `hit_mem0` is asserted.
- R4: `hit_none` is 1 exactly when neither window is selected.
- R5: With `ovr_mode` = 2'b01, Mem0 is selected exactly when `cpu_addr[31:30]` equals `mem0_base[10:9]` (1 GB window).
- R6: With `ovr_mode` = 2'b10, Mem0 is selected exactly when `cpu_addr[31]` equals `mem0_base[10]` (2 GB window).
- R7: When the override is on (2'b01 or 2'b10) and its compare fails, `hit_mem0` is 0 and `hit_mem1` follows the normal Mem1 compare.
- R8: `ovr_mode` values 2'b00 and 2'b11 both turn the override off and give the default decode.
- R9: Exactly one of `hit_mem0`, `hit_mem1`, `hit_none` is 1 for every input.
- R10: `cpu_addr[27:0]` and bits 6:0 of both base registers have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr | input | 32 | CPU address being decoded |
| ovr_mode | input | 2 | Override field: 00 off, 01 1 GB, 10 2 GB, 11 off |
| mem0_base | input | 11 | Mem0 low decode register (bit 10 is address bit 31) |
| mem1_base | input | 11 | Mem1 low decode register (bit 10 is address bit 31) |
| hit_mem0 | output | 1 | Access goes to Mem0 |
| hit_mem1 | output | 1 | Access goes to Mem1 |
| hit_none | output | 1 | Access targets neither window |

## Verification
The block holds no state, so a wrong internal compare shows up at the ports for the same input it mishandles. A compare bit that is swapped, or a missing fallback, changes the one-hot target at once. For that reason the bench sweeps every override mode, every value of the top address nibble, and every value of the top nibble of both base registers. The remaining bits are filled with random values, so that a dependence on bits that should be ignored is exposed.

// File: rtl/pci_win_pkg.sv
package pci_win_pkg;

    typedef enum logic [1:0] {
        OVR_OFF  = 2'b00,
        OVR_1G   = 2'b01,
        OVR_2G   = 2'b10,
        OVR_RSVD = 2'b11
    } ovr_mode_e;

    typedef struct packed {
        logic mem0;
        logic mem1;
        logic none;
    } target_t;

endpackage

// File: rtl/win_cmp.sv
// Compares the top CMP_BITS of an address with the top bits of a decode register.
module win_cmp #(
    parameter int CMP_BITS = 4
) (
    input  logic [CMP_BITS-1:0] addr_top,
    input  logic [CMP_BITS-1:0] base_top,
    output logic                match
);
    always_comb begin
        match = (addr_top == base_top);
    end
endmodule

// File: rtl/target_sel.sv
// Applies the override mode, the fallback and the Mem0 priority.
module target_sel
    import pci_win_pkg::*;
(
    input  ovr_mode_e mode,
    input  logic      norm0,
    input  logic      norm1,
    input  logic      ovr1g,
    input  logic      ovr2g,
    output target_t   tgt
);
    target_t tgt_d;
    logic    ovr_on;
    logic    ovr_hit;

    always_comb begin
        ovr_on  = (mode == OVR_1G) || (mode == OVR_2G);
        ovr_hit = (mode == OVR_1G) ? ovr1g : ovr2g;
        tgt_d   = '0;
        if (ovr_on) begin
            tgt_d.mem0 = ovr_hit;
        end else begin
            tgt_d.mem0 = norm0;
        end
        tgt_d.mem1 = !tgt_d.mem0 && norm1;
        tgt_d.none = !tgt_d.mem0 && !tgt_d.mem1;
        tgt = tgt_d;
    end

    always_comb begin
        if ((mode == OVR_OFF || mode == OVR_RSVD) && norm0 && norm1)
            assert_mem0_priority_R3: assert (tgt.mem0 && !tgt.mem1)
                else $error("R3 priority violated");
        if (ovr_on && !ovr_hit)
            assert_fallback_R7: assert (!tgt.mem0 && (tgt.mem1 == norm1))
                else $error("R7 fallback violated");
        if (tgt.none)
            assert_no_target_R4: assert (!norm1 || (ovr_on && ovr_hit))
                else $error("R4 no-target while Mem1 matches");
    end
endmodule

// File: rtl/pci_win_decode.sv
module pci_win_decode
    import pci_win_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int REG_W   = 11,
    parameter int WIN_BITS = 4
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        ovr_mode,
    input  logic [REG_W-1:0]  mem0_base,
    input  logic [REG_W-1:0]  mem1_base,
    output logic              hit_mem0,
    output logic              hit_mem1,
    output logic              hit_none
);
    localparam int NUM_WIN = 2;
    localparam int A_LO    = ADDR_W - WIN_BITS;
    localparam int R_LO    = REG_W - WIN_BITS;

    logic [REG_W-1:0] bases [NUM_WIN];
    logic [NUM_WIN-1:0] norm;
    logic ovr1g, ovr2g;
    target_t tgt;

    assign bases[0] = mem0_base;
    assign bases[1] = mem1_base;

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            win_cmp #(.CMP_BITS(WIN_BITS)) u_norm (
                .addr_top(cpu_addr[ADDR_W-1:A_LO]),
                .base_top(bases[w][REG_W-1:R_LO]),
                .match   (norm[w])
            );
        end
    endgenerate

    win_cmp #(.CMP_BITS(2)) u_ovr1g (
        .addr_top(cpu_addr[ADDR_W-1:ADDR_W-2]),
        .base_top(mem0_base[REG_W-1:REG_W-2]),
        .match   (ovr1g)
    );

    win_cmp #(.CMP_BITS(1)) u_ovr2g (
        .addr_top(cpu_addr[ADDR_W-1:ADDR_W-1]),
        .base_top(mem0_base[REG_W-1:REG_W-1]),
        .match   (ovr2g)
    );

    target_sel u_sel (
        .mode (ovr_mode_e'(ovr_mode)),
        .norm0(norm[0]),
        .norm1(norm[1]),
        .ovr1g(ovr1g),
        .ovr2g(ovr2g),
        .tgt  (tgt)
    );

    assign hit_mem0 = tgt.mem0;
    assign hit_mem1 = tgt.mem1;
    assign hit_none = tgt.none;

    logic unused_bits;
    assign unused_bits = ^{cpu_addr[A_LO-1:0], mem0_base[R_LO-1:0], mem1_base[R_LO-1:0]};

    always_comb begin
        assert_onehot_R9: assert ($onehot({hit_mem0, hit_mem1, hit_none}))
            else $error("R9 target not one-hot");
        if (ovr_mode == 2'b01 && hit_mem0)
            assert_ovr_1g_R5: assert (cpu_addr[ADDR_W-1:ADDR_W-2] == mem0_base[REG_W-1:REG_W-2])
                else $error("R5 1G override mismatch");
        if (ovr_mode == 2'b10 && hit_mem0)
            assert_ovr_2g_R6: assert (cpu_addr[ADDR_W-1] == mem0_base[REG_W-1])
                else $error("R6 2G override mismatch");
    end
endmodule

// File: tb/tb_pci_win_decode.sv
module tb_pci_win_decode;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] cpu_addr;
    logic [1:0]  ovr_mode;
    logic [10:0] mem0_base, mem1_base;
    logic        hit_mem0, hit_mem1, hit_none;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    pci_win_decode dut (
        .cpu_addr (cpu_addr),
        .ovr_mode (ovr_mode),
        .mem0_base(mem0_base),
        .mem1_base(mem1_base),
        .hit_mem0 (hit_mem0),
        .hit_mem1 (hit_mem1),
        .hit_none (hit_none)
    );

    // Reference model, written from the requirements.
    function automatic logic [2:0] model(input logic [31:0] a, input logic [1:0] m,
                                         input logic [10:0] b0, input logic [10:0] b1);
        int top, t0, t1;
        logic act, ov, e0, e1;
        top = int'(a >> 28);
        t0  = int'(b0 >> 7);
        t1  = int'(b1 >> 7);
        act = (m == 2'd1) || (m == 2'd2);
        if (m == 2'd1)      ov = (int'(a >> 30) == int'(b0 >> 9));
        else if (m == 2'd2) ov = (int'(a >> 31) == int'(b0 >> 10));
        else                ov = 1'b0;
        e0 = act ? ov : (top == t0);
        e1 = !e0 && (top == t1);
        return {e0, e1, !e0 && !e1};
    endfunction

    function automatic string tag_of(input logic [31:0] a, input logic [1:0] m,
                                     input logic [10:0] b0, input logic [10:0] b1);
        logic [2:0] e;
        e = model(a, m, b0, b1);
        if (m == 2'd3) return "R8";
        if (m == 2'd1) return e[2] ? "R5" : "R7";
        if (m == 2'd2) return e[2] ? "R6" : "R7";
        if (e[2] && (a[31:28] == b1[10:7])) return "R3";
        if (e[2]) return "R1";
        if (e[1]) return "R2";
        return "R4";
    endfunction

    task automatic check(input string tag, input logic [2:0] exp);
        logic [2:0] act;
        act = {hit_mem0, hit_mem1, hit_none};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h mode=%0d b0=%h b1=%h actual=%b expected=%b",
                     tag, cpu_addr, ovr_mode, mem0_base, mem1_base, act, exp);
        end
        n_cmp++;
        if (!$onehot(act)) begin
            n_bad++;
            $display("FAIL R9 not one-hot actual=%b expected one-hot %b", act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [1:0] m,
                         input logic [10:0] b0, input logic [10:0] b1, input string tag);
        @(posedge clk);
        cpu_addr = a; ovr_mode = m; mem0_base = b0; mem1_base = b1;
        @(negedge clk);
        check(tag, model(a, m, b0, b1));
    endtask

    initial begin
        cpu_addr = '0; ovr_mode = '0; mem0_base = '0; mem1_base = 11'h400;
        @(negedge clk);
        // Initial state: address 0 hits Mem0 at base 0 (R1).
        check("R1", 3'b100);

        // Full sweep of mode, address nibble and both base nibbles.
        for (int m = 0; m < 4; m++)
            for (int t = 0; t < 16; t++)
                for (int b0 = 0; b0 < 16; b0++)
                    for (int b1 = 0; b1 < 16; b1++) begin
                        logic [31:0] a;
                        logic [10:0] r0, r1;
                        a  = {t[3:0], 28'($urandom)};
                        r0 = {b0[3:0], 7'($urandom)};
                        r1 = {b1[3:0], 7'($urandom)};
                        apply(a, m[1:0], r0, r1, tag_of(a, m[1:0], r0, r1));
                    end

        // R10: the low bits alone change; the result must stay fixed.
        for (int i = 0; i < 64; i++) begin
            logic [1:0] m;
            m = 2'(i);
            apply({4'hA, 28'($urandom)}, m, {4'hA, 7'($urandom)},
                  {4'h2, 7'($urandom)}, "R10");
        end
        // R10 with explicit expected values: override 2G, addr bit31 = 1, base bit10 = 1.
        @(posedge clk);
        cpu_addr = 32'h8FFF_FFFF; ovr_mode = 2'b10; mem0_base = 11'h47F; mem1_base = 11'h07F;
        @(negedge clk);
        check("R10", 3'b100);
        @(posedge clk);
        cpu_addr = 32'h0000_0000; ovr_mode = 2'b10; mem0_base = 11'h400; mem1_base = 11'h000;
        @(negedge clk);
        check("R7", 3'b010);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule